// File: doc/BRIEF.md
# Lookup-Table Input Stuck-At Fault Injector

This block rewrites the truth table of a K-input lookup table (four inputs and sixteen entries by default) so that the table behaves as if one of its input pins were stuck at a constant level. When a pin is held at a fixed value, half of the table can no longer be addressed. The block models this by overwriting each unreachable entry with the entry the faulty pin forces the address onto. The input pin index sets the spacing between source and destination entries, which is one, two, four or eight positions. The stuck level sets the direction of the copy.

A request supplies the original table, the pin index, the stuck level and an enable. One clock later the block presents the resulting table together with a one-cycle valid strobe. With the enable low, the table passes through untouched. Between requests the output holds its last value. The block is meant for fault-repair experiments, where a faulted configuration is built from a healthy one before it is written back.

Top module: `lut_fault_inject`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle in which `req_i` was high, and low otherwise.
- R2: With `en_i` low at the request, `table_o` equals the requested `table_i` bit for bit.
- R3: With `en_i` high and `stuck_i` = 0 on pin p, every output entry at address a equals input entry a with bit p cleared. Entry index a is the bit position in the table vector.
- R4: With `en_i` high and `stuck_i` = 1 on pin p, every output entry at address a equals input entry a with bit p set.
- R5: Entries whose address bit p already equals the stuck level keep their original value.
- R6: After a fault on pin p, every two entries whose addresses differ only in bit p hold equal values.
- R7: Applying the same fault to an already faulted table leaves that table unchanged.
- R8: While `rst_ni` is low, `table_o` is all zeros and `valid_o` is 0.
- R9: In a cycle without a request, `table_o` keeps its previous value, whatever happens on the other inputs.
- R10: A table that does not depend on pin p, such as a 3-input function duplicated across the fourth input, comes out unchanged when pin p is faulted at either level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; the inputs are captured when it is high |
| en_i | input | 1 | 1 applies the fault, 0 passes the table through |
| pin_i | input | PIN_W (2) | Index of the faulty input pin |
| stuck_i | input | 1 | Level the pin is stuck at |
| table_i | input | ENTRIES (16) | Original truth table, bit a holds the entry at address a |
| table_o | output | ENTRIES (16) | Resulting truth table |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with its default four inputs, so the pin index, the stuck level and the enable form only sixteen combinations. Every combination is swept over a set of fixed and pseudo-random tables, each compared entry by entry with a fold computed arithmetically in the bench. The small table size also lets the bench build pin-independent tables for every pin, and feed each result back in to check that a second fault changes nothing.

// File: rtl/lut_fault_pkg.sv
package lut_fault_pkg;

  typedef enum logic {
    STUCK_LO = 1'b0,
    STUCK_HI = 1'b1
  } stuck_e;

  function automatic int unsigned pin_width(int unsigned inputs);
    return (inputs > 1) ? $clog2(inputs) : 1;
  endfunction

endpackage

// File: rtl/lut_pin_fold.sv
// Folds the table along one address bit: every entry takes the value of the
// entry reached with bit PIN forced to the stuck level.
module lut_pin_fold #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PIN     = 0
) (
  input  logic                   stuck_i,
  input  logic [ENTRIES-1:0]     table_i,
  output logic [ENTRIES-1:0]     table_o
);
  localparam int unsigned STRIDE = 1 << PIN;

  for (genvar a = 0; a < ENTRIES; a++) begin : g_entry
    localparam int unsigned SRC_LO = a & ~STRIDE;
    localparam int unsigned SRC_HI = a | STRIDE;
    assign table_o[a] = stuck_i ? table_i[SRC_HI] : table_i[SRC_LO];
  end

endmodule

// File: rtl/lut_fault_select.sv
module lut_fault_select #(
  parameter int unsigned INPUTS  = 4,
  parameter int unsigned ENTRIES = 1 << INPUTS,
  parameter int unsigned PIN_W   = 2
) (
  input  logic                   en_i,
  input  logic [PIN_W-1:0]       pin_i,
  input  lut_fault_pkg::stuck_e  stuck_i,
  input  logic [ENTRIES-1:0]     table_i,
  output logic [ENTRIES-1:0]     table_o
);
  localparam int unsigned SLOTS = 1 << PIN_W;

  logic [ENTRIES-1:0] folded [SLOTS];

  for (genvar p = 0; p < SLOTS; p++) begin : g_pin
    if (p < INPUTS) begin : g_real
      lut_pin_fold #(
        .ENTRIES (ENTRIES),
        .PIN     (p)
      ) u_fold (
        .stuck_i (stuck_i == lut_fault_pkg::STUCK_HI),
        .table_i (table_i),
        .table_o (folded[p])
      );
    end else begin : g_none
      // pin index beyond the table: no fault to model
      assign folded[p] = table_i;
    end
  end

  assign table_o = en_i ? folded[pin_i] : table_i;

endmodule

// File: rtl/lut_fault_reg.sv
module lut_fault_reg #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PIN_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               en_i,
  input  logic [PIN_W-1:0]   pin_i,
  input  logic               stuck_i,
  input  logic [ENTRIES-1:0] table_d_i,
  output logic [ENTRIES-1:0] table_q_o,
  output logic               valid_o,
  output logic               en_q_o,
  output logic [PIN_W-1:0]   pin_q_o,
  output logic               stuck_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      table_q_o <= '0;
      valid_o   <= 1'b0;
      en_q_o    <= 1'b0;
      pin_q_o   <= '0;
      stuck_q_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        table_q_o <= table_d_i;
        en_q_o    <= en_i;
        pin_q_o   <= pin_i;
        stuck_q_o <= stuck_i;
      end
    end
  end

  a_r1_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r1_valid_only_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(table_q_o));

endmodule

// File: rtl/lut_fault_inject.sv
module lut_fault_inject #(
  parameter int unsigned LUT_INPUTS = 4,
  localparam int unsigned ENTRIES   = 1 << LUT_INPUTS,
  localparam int unsigned PIN_W     = lut_fault_pkg::pin_width(LUT_INPUTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               en_i,
  input  logic [PIN_W-1:0]   pin_i,
  input  logic               stuck_i,
  input  logic [ENTRIES-1:0] table_i,
  output logic [ENTRIES-1:0] table_o,
  output logic               valid_o
);

  logic [ENTRIES-1:0] table_d;
  logic               en_q;
  logic [PIN_W-1:0]   pin_q;
  logic               stuck_q;

  lut_fault_select #(
    .INPUTS  (LUT_INPUTS),
    .ENTRIES (ENTRIES),
    .PIN_W   (PIN_W)
  ) u_select (
    .en_i    (en_i),
    .pin_i   (pin_i),
    .stuck_i (lut_fault_pkg::stuck_e'(stuck_i)),
    .table_i (table_i),
    .table_o (table_d)
  );

  lut_fault_reg #(
    .ENTRIES (ENTRIES),
    .PIN_W   (PIN_W)
  ) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .en_i      (en_i),
    .pin_i     (pin_i),
    .stuck_i   (stuck_i),
    .table_d_i (table_d),
    .table_q_o (table_o),
    .valid_o   (valid_o),
    .en_q_o    (en_q),
    .pin_q_o   (pin_q),
    .stuck_q_o (stuck_q)
  );

  // Checker-side views of the registered result
  logic               pairs_equal;
  logic [ENTRIES-1:0] keep_mask;

  always_comb begin
    pairs_equal = 1'b1;
    keep_mask   = '0;
    for (int a = 0; a < ENTRIES; a++) begin
      if (int'(pin_q) < int'(LUT_INPUTS)) begin
        if (table_o[a] != table_o[a ^ (1 << pin_q)]) pairs_equal = 1'b0;
        keep_mask[a] = (((a >> pin_q) & 1) == int'(stuck_q));
      end else begin
        keep_mask[a] = 1'b1;
      end
    end
  end

  a_r2_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !en_i) |=> (table_o == $past(table_i)));
  a_r5_reachable_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((table_o & keep_mask) == ($past(table_i) & keep_mask)));
  a_r6_pairs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && en_q) |-> pairs_equal);
  a_r8_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (table_o == '0 && !valid_o));

endmodule

// File: tb/lut_fault_inject_tb.sv
`timescale 1ns/1ps
module lut_fault_inject_tb;
  localparam int K = 4;
  localparam int N = 1 << K;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req = 1'b0;
  logic         en = 1'b0;
  logic [1:0]   pin = '0;
  logic         stuck = 1'b0;
  logic [N-1:0] tin = '0;
  logic [N-1:0] tout;
  logic         valid;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  lut_fault_inject #(.LUT_INPUTS(K)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .en_i(en), .pin_i(pin),
    .stuck_i(stuck), .table_i(tin), .table_o(tout), .valid_o(valid)
  );

  function automatic logic [N-1:0] fold(logic [N-1:0] t, int p, logic v);
    logic [N-1:0] r;
    for (int a = 0; a < N; a++) r[a] = v ? t[a | (1 << p)] : t[a & ~(1 << p)];
    return r;
  endfunction

  function automatic logic [15:0] step(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(string req_tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic issue(logic [N-1:0] t, int p, logic v, logic e);
    @(negedge clk);
    tin = t; pin = 2'(p); stuck = v; en = e; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R1 valid after req", {15'b0, valid}, 16'h1);
  endtask

  task automatic run_fault(logic [N-1:0] t, int p, logic v);
    logic [N-1:0] exp, first;
    exp = fold(t, p, v);
    issue(t, p, v, 1'b1);
    check(v ? "R4 stuck-at-1 fold" : "R3 stuck-at-0 fold", tout, exp);
    for (int a = 0; a < N; a++)
      if (((a >> p) & 1) == int'(v))
        check("R5 reachable entry kept", {15'b0, tout[a]}, {15'b0, t[a]});
    for (int a = 0; a < N; a++)
      check("R6 pair equal", {15'b0, tout[a]}, {15'b0, tout[a ^ (1 << p)]});
    first = tout;
    // R9: idle cycle with changed inputs must not disturb the output
    tin = ~t; en = ~en; pin = pin + 2'd1;
    @(negedge clk);
    check("R9 hold table", tout, first);
    check("R1 valid low idle", {15'b0, valid}, 16'h0);
    issue(first, p, v, 1'b1);
    check("R7 idempotent", tout, first);
  endtask

  initial begin
    #20000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] fixed [8];
    fixed[0] = 16'h00E8; fixed[1] = 16'h0096; fixed[2] = 16'h008E;
    fixed[3] = 16'h0000; fixed[4] = 16'hFFFF; fixed[5] = 16'hAAAA;
    fixed[6] = 16'h8001; fixed[7] = 16'h1234;

    #1;
    @(negedge clk);
    check("R8 reset table", tout, '0);
    check("R8 reset valid", {15'b0, valid}, 16'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      issue(fixed[i], i % 4, i[0], 1'b0);
      check("R2 bypass", tout, fixed[i]);
    end
    for (int i = 0; i < 16; i++) begin
      lfsr = step(lfsr);
      issue(lfsr, i % 4, i[2], 1'b0);
      check("R2 bypass random", tout, lfsr);
    end

    for (int i = 0; i < 8; i++)
      for (int p = 0; p < K; p++)
        for (int v = 0; v < 2; v++)
          run_fault(fixed[i], p, v[0]);

    for (int i = 0; i < 24; i++) begin
      lfsr = step(lfsr);
      for (int p = 0; p < K; p++)
        for (int v = 0; v < 2; v++)
          run_fault(lfsr, p, v[0]);
    end

    // R10: tables independent of the faulted pin stay unchanged
    for (int p = 0; p < K; p++)
      for (int v = 0; v < 2; v++) begin
        logic [N-1:0] indep;
        issue(16'hE8E8, 3, v[0], 1'b1);
        check("R10 3-input function, pin 3", tout, 16'hE8E8);
        lfsr = step(lfsr);
        indep = fold(lfsr, p, ~v[0]);
        issue(indep, p, v[0], 1'b1);
        check("R10 pin-independent table", tout, indep);
      end

    // R8: asynchronous reset mid-run clears the output
    issue(16'h5A5A, 0, 1'b1, 1'b0);
    #1 rst_ni = 1'b0;
    #1;
    check("R8 async reset table", tout, '0);
    check("R8 async reset valid", {15'b0, valid}, 16'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule